// File: doc/BRIEF.md
# Serial Flash Read Command Engine

This block is the device-side front end of a serial NOR flash for read traffic. While chip select is low it samples an 8-bit command on the rising edges of the serial clock, then a 24-bit or 32-bit start address, optionally skips a fixed run of idle clocks, and then streams bytes out of a small on-chip array. Data leaves on one, two or four lanes and changes on the falling clock edge. The read address advances by one after every byte, so one command can read on for as long as chip select stays low.

Two families of read command exist. The wide-address family always takes a 32-bit address. The classic family takes 24 or 32 bits, chosen by an address-width flag. That flag is loaded from a configuration input during reset and can be switched at run time by two single-byte commands. The array is preloaded during reset with a computed pattern, so reads return known data.

Top module: `sflash_read_engine`

## Requirements
- R1: While rst_n is low or cs_n is high, dq_oe is 4'b0000. Raising cs_n abandons any command, and the next low period of cs_n starts with a fresh command byte.
- R2: The command byte is taken MSB first from dq_in[0], one bit per rising edge of sck.
- R3: Commands 13h, 0Ch, 3Ch, BCh, 6Ch and ECh always take a 32-bit address, whatever the value of the address-width flag.
- R4: Commands 03h, 0Bh, 3Bh, BBh, 6Bh and EBh take a 24-bit address when the flag is 0 and a 32-bit address when it is 1.
- R5: During reset the flag takes the value of cfg_addr4. Command B7h sets it and command E9h clears it. It keeps its value across cs_n cycles.
- R6: The address is sent MSB first on rising edges. BBh/BCh use 2 bits per clock on dq_in[1:0]. EBh/ECh use 4 bits per clock on dq_in[3:0]. All other reads use dq_in[0].
- R7: 03h and 13h have no idle clocks between the address and the data. Every other read has 8 idle clocks there. dq_oe stays 0 until the data starts.
- R8: Data changes on the falling edge of sck, MSB first. Single-lane reads use dq_out[1] with dq_oe=0010. 3Bh/3Ch/BBh/BCh use dq_out[1:0] with dq_oe=0011, and bit 1 carries the higher bit. 6Bh/6Ch/EBh/ECh use dq_out[3:0] with dq_oe=1111, and bit 3 carries the highest bit.
- R9: After each byte the read address increments by one. Only its low MEM_AW bits select the array entry, and it wraps from the top entry to entry 0.
- R10: Any other command byte makes the engine ignore the rest of the low period of cs_n, with dq_oe held at 0.
- R11: After reset, array entry i holds (37*i + 90) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sck | input | 1 | Serial clock |
| rst_n | input | 1 | Active-low reset; loads the flag and preloads the array |
| cs_n | input | 1 | Active-low chip select; frames one command |
| cfg_addr4 | input | 1 | Value the address-width flag takes during reset |
| dq_in | input | 4 | Serial data lanes, host to device |
| dq_out | output | 4 | Serial data lanes, device to host |
| dq_oe | output | 4 | Per-lane output enable for dq_out |

## Verification
Almost any internal fault shows up as wrong data. A bit counter that is off by one, or a wrong idle count, skews every data beat, so the first byte of the read already comes out wrong. A wrong address width, or a wrong address-width flag, shows the same way within the first byte: the array is preloaded with all-distinct values, so data from the wrong entry cannot look right. A fault in the address increment or the wrap first appears at the second byte, or at the byte that crosses the top of the array. A fault in chip-select handling or in command rejection shows as dq_oe rising outside a data phase. The bench checks for that on every clock.

// File: rtl/sflash_read_engine.sv
module sflash_read_engine #(
  parameter int MEM_AW     = 8,
  parameter int DUMMY_CLKS = 8
) (
  input  logic       sck,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       cfg_addr4,
  input  logic [3:0] dq_in,
  output logic [3:0] dq_out,
  output logic [3:0] dq_oe
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam logic [2:0] PH_OPC = 3'd0, PH_ADDR = 3'd1, PH_DUMMY = 3'd2,
                         PH_DATA = 3'd3, PH_SKIP = 3'd4;

  logic              clr;
  logic [2:0]        phase;
  logic [5:0]        cnt;
  logic [6:0]        op_sr;
  logic [31:0]       a_sr, a_nxt;
  logic [1:0]        alog, dlog;
  logic              fast;
  logic [5:0]        aclks;
  logic [7:0]        sh, sh_adv;
  logic [MEM_AW-1:0] rd_addr;
  logic [2:0]        beat, beat_last;
  logic              mode4;
  logic [7:0]        mem [DEPTH];

  logic [7:0] op_now;
  logic       d_ok, d_f4, d_fast;
  logic [1:0] d_alog, d_dlog;
  logic [5:0] d_aclks;

  assign clr    = cs_n | ~rst_n;
  assign op_now = {op_sr, dq_in[0]};

  always_comb begin
    {d_ok, d_f4, d_fast, d_alog, d_dlog} = '0;
    case (op_now)
      8'h03: {d_ok, d_f4, d_fast, d_alog, d_dlog} = {3'b100, 2'd0, 2'd0};
      8'h13: {d_ok, d_f4, d_fast, d_alog, d_dlog} = {3'b110, 2'd0, 2'd0};
      8'h0B: {d_ok, d_f4, d_fast, d_alog, d_dlog} = {3'b101, 2'd0, 2'd0};
      8'h0C: {d_ok, d_f4, d_fast, d_alog, d_dlog} = {3'b111, 2'd0, 2'd0};
      8'h3B: {d_ok, d_f4, d_fast, d_alog, d_dlog} = {3'b101, 2'd0, 2'd1};
      8'h3C: {d_ok, d_f4, d_fast, d_alog, d_dlog} = {3'b111, 2'd0, 2'd1};
      8'hBB: {d_ok, d_f4, d_fast, d_alog, d_dlog} = {3'b101, 2'd1, 2'd1};
      8'hBC: {d_ok, d_f4, d_fast, d_alog, d_dlog} = {3'b111, 2'd1, 2'd1};
      8'h6B: {d_ok, d_f4, d_fast, d_alog, d_dlog} = {3'b101, 2'd0, 2'd2};
      8'h6C: {d_ok, d_f4, d_fast, d_alog, d_dlog} = {3'b111, 2'd0, 2'd2};
      8'hEB: {d_ok, d_f4, d_fast, d_alog, d_dlog} = {3'b101, 2'd2, 2'd2};
      8'hEC: {d_ok, d_f4, d_fast, d_alog, d_dlog} = {3'b111, 2'd2, 2'd2};
      default: ;
    endcase
  end

  assign d_aclks = (d_f4 || mode4) ? (6'd32 >> d_alog) : (6'd24 >> d_alog);

  always_comb begin
    case (alog)
      2'd0:    a_nxt = {a_sr[30:0], dq_in[0]};
      2'd1:    a_nxt = {a_sr[29:0], dq_in[1:0]};
      default: a_nxt = {a_sr[27:0], dq_in};
    endcase
    case (dlog)
      2'd0:    begin sh_adv = {sh[6:0], 1'b0}; beat_last = 3'd7; end
      2'd1:    begin sh_adv = {sh[5:0], 2'b0}; beat_last = 3'd3; end
      default: begin sh_adv = {sh[3:0], 4'b0}; beat_last = 3'd1; end
    endcase
  end

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'((i * 37 + 90) % 256);
    end
  end

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) mode4 <= cfg_addr4;
    else if (!cs_n && phase == PH_OPC && cnt == 6'd7) begin
      if (op_now == 8'hB7)      mode4 <= 1'b1;
      else if (op_now == 8'hE9) mode4 <= 1'b0;
    end
  end

  always_ff @(posedge sck or posedge clr) begin
    if (clr) begin
      phase   <= PH_OPC;
      cnt     <= '0;
      op_sr   <= '0;
      a_sr    <= '0;
      alog    <= '0;
      dlog    <= '0;
      fast    <= 1'b0;
      aclks   <= '0;
      sh      <= '0;
      rd_addr <= '0;
      beat    <= '0;
    end else begin
      case (phase)
        PH_OPC: begin
          op_sr <= op_now[6:0];
          cnt   <= cnt + 6'd1;
          if (cnt == 6'd7) begin
            cnt   <= '0;
            alog  <= d_alog;
            dlog  <= d_dlog;
            fast  <= d_fast;
            aclks <= d_aclks;
            phase <= d_ok ? PH_ADDR : PH_SKIP;
          end
        end
        PH_ADDR: begin
          a_sr <= a_nxt;
          cnt  <= cnt + 6'd1;
          if (cnt == aclks - 6'd1) begin
            cnt <= '0;
            if (fast && DUMMY_CLKS > 0) phase <= PH_DUMMY;
            else begin
              sh      <= mem[a_nxt[MEM_AW-1:0]];
              rd_addr <= a_nxt[MEM_AW-1:0] + 1'b1;
              beat    <= '0;
              phase   <= PH_DATA;
            end
          end
        end
        PH_DUMMY: begin
          cnt <= cnt + 6'd1;
          if (cnt == 6'(DUMMY_CLKS - 1)) begin
            sh      <= mem[a_sr[MEM_AW-1:0]];
            rd_addr <= a_sr[MEM_AW-1:0] + 1'b1;
            beat    <= '0;
            phase   <= PH_DATA;
          end
        end
        PH_DATA: begin
          if (beat == beat_last) begin
            sh      <= mem[rd_addr];
            rd_addr <= rd_addr + 1'b1;
            beat    <= '0;
          end else begin
            sh   <= sh_adv;
            beat <= beat + 3'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge sck or posedge clr) begin
    if (clr) begin
      dq_out <= '0;
      dq_oe  <= '0;
    end else if (phase == PH_DATA) begin
      case (dlog)
        2'd0:    begin dq_out <= {2'b0, sh[7], 1'b0}; dq_oe <= 4'b0010; end
        2'd1:    begin dq_out <= {2'b0, sh[7:6]};     dq_oe <= 4'b0011; end
        default: begin dq_out <= sh[7:4];             dq_oe <= 4'b1111; end
      endcase
    end else begin
      dq_out <= '0;
      dq_oe  <= '0;
    end
  end
endmodule

// File: rtl/sflash_read_engine_chk.sv
module sflash_read_engine_chk (
  input logic       sck,
  input logic       rst_n,
  input logic       cs_n,
  input logic [2:0] phase,
  input logic [5:0] cnt,
  input logic       mode4,
  input logic [3:0] dq_oe
);
  assert_idle_quiet_R1: assert property (@(posedge sck) disable iff (!rst_n)
    cs_n |-> dq_oe == 4'b0000);

  assert_lane_sets_R8: assert property (@(posedge sck) disable iff (!rst_n)
    dq_oe inside {4'b0000, 4'b0010, 4'b0011, 4'b1111});

  assert_drive_in_data_R7: assert property (@(posedge sck) disable iff (!rst_n)
    (dq_oe != 4'b0000) |-> phase == 3'd3);

  assert_mode_by_cmd_R5: assert property (@(posedge sck) disable iff (!rst_n)
    (mode4 != $past(mode4)) |-> ($past(phase) == 3'd0 && $past(cnt) == 6'd7 && !$past(cs_n)));

  assert_reject_silent_R10: assert property (@(posedge sck) disable iff (!rst_n)
    phase == 3'd4 |-> dq_oe == 4'b0000);
endmodule

bind sflash_read_engine sflash_read_engine_chk u_chk (
  .sck(sck), .rst_n(rst_n), .cs_n(cs_n), .phase(phase),
  .cnt(cnt), .mode4(mode4), .dq_oe(dq_oe)
);

// File: tb/sflash_read_engine_bench.sv
module sflash_read_engine_bench;
  localparam int SCK_PERIOD = 20;
  localparam int MEM_AW = 8;

  logic sck = 1'b0, rst_n = 1'b0, cs_n = 1'b1, cfg_addr4 = 1'b0;
  logic [3:0] dq_in = '0;
  logic [3:0] dq_out, dq_oe;

  int checks = 0, errors = 0;
  bit mode_m = 1'b0;

  sflash_read_engine u_sflash_read_engine (
    .sck(sck), .rst_n(rst_n), .cs_n(cs_n), .cfg_addr4(cfg_addr4),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [7:0] mem_byte(input int idx);
    return 8'(((idx % (1 << MEM_AW)) * 37 + 90) % 256);
  endfunction

  function automatic void op_info(input logic [7:0] op, output bit f4,
                                  output int alog, output int dlog, output bit fast);
    f4 = (op == 8'h13 || op == 8'h0C || op == 8'h3C || op == 8'hBC || op == 8'h6C || op == 8'hEC);
    fast = !(op == 8'h03 || op == 8'h13);
    alog = (op == 8'hBB || op == 8'hBC) ? 1 : (op == 8'hEB || op == 8'hEC) ? 2 : 0;
    dlog = (op == 8'h03 || op == 8'h13 || op == 8'h0B || op == 8'h0C) ? 0 :
           (op == 8'h3B || op == 8'h3C || op == 8'hBB || op == 8'hBC) ? 1 : 2;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic [3:0] d, output logic [3:0] q, output logic [3:0] oe);
    dq_in = d;
    #(SCK_PERIOD / 4);
    q  = dq_out;
    oe = dq_oe;
    #(SCK_PERIOD / 4);
    sck = 1'b1;
    #(SCK_PERIOD / 2);
    sck = 1'b0;
  endtask

  task automatic do_reset(input bit cfg);
    logic [3:0] q, oe;
    rst_n = 1'b0; cs_n = 1'b1; cfg_addr4 = cfg;
    for (int i = 0; i < 3; i++) tick(4'h0, q, oe);
    rst_n = 1'b1;
    mode_m = cfg;
    tick(4'h0, q, oe);
  endtask

  task automatic idle_check(input int n, input string tag);
    logic [3:0] q, oe;
    bit quiet = 1'b1;
    logic [3:0] seen = '0;
    cs_n = 1'b1;
    for (int i = 0; i < n; i++) begin
      tick(4'($urandom), q, oe);
      if (oe != 4'b0000) begin quiet = 1'b0; seen = oe; end
    end
    check(quiet, tag, 32'(seen), 32'h0);
  endtask

  task automatic send_cmd(input logic [7:0] op);
    logic [3:0] q, oe;
    cs_n = 1'b0;
    for (int i = 0; i < 8; i++) tick({3'b0, op[7-i]}, q, oe);
    cs_n = 1'b1;
    if (op == 8'hB7) mode_m = 1'b1;
    if (op == 8'hE9) mode_m = 1'b0;
    tick(4'h0, q, oe);
  endtask

  task automatic read_txn(input logic [7:0] op, input logic [31:0] addr, input int nb, input string tag);
    logic [3:0] q, oe;
    bit f4, fast, quiet;
    int alog, dlog, al, dl, abits, aclk, idx;
    logic [3:0] emask;
    op_info(op, f4, alog, dlog, fast);
    al = 1 << alog; dl = 1 << dlog;
    abits = (f4 || mode_m) ? 32 : 24;
    aclk = abits / al;
    emask = (dl == 1) ? 4'b0010 : (dl == 2) ? 4'b0011 : 4'b1111;
    quiet = 1'b1;
    cs_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick({3'b0, op[7-i]}, q, oe);
      if (oe != 4'b0000) quiet = 1'b0;
    end
    for (int i = 0; i < aclk; i++) begin
      logic [31:0] ch;
      ch = (addr >> (abits - al * (i + 1))) & ((32'd1 << al) - 32'd1);
      tick(ch[3:0], q, oe);
      if (oe != 4'b0000) quiet = 1'b0;
    end
    if (fast) for (int i = 0; i < 8; i++) begin
      tick(4'($urandom), q, oe);
      if (oe != 4'b0000) quiet = 1'b0;
    end
    check(quiet, "R7 no drive before data", 32'(!quiet), 32'h0);
    idx = int'(addr[MEM_AW-1:0]);
    for (int b = 0; b < nb; b++) begin
      logic [7:0] got, exp;
      bit oe_ok;
      got = '0; oe_ok = 1'b1;
      for (int j = 0; j < 8 / dl; j++) begin
        tick(4'($urandom), q, oe);
        if (oe != emask) oe_ok = 1'b0;
        if (dl == 1)      got = {got[6:0], q[1]};
        else if (dl == 2) got = {got[5:0], q[1:0]};
        else              got = {got[3:0], q};
      end
      exp = mem_byte(idx + b);
      check(got == exp, tag, 32'(got), 32'(exp));
      check(oe_ok, "R8 lane enables", 32'(oe), 32'(emask));
    end
    cs_n = 1'b1;
    tick(4'h0, q, oe);
  endtask

  initial begin
    #(SCK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] q, oe;
    void'($urandom(32'd20240611));
    do_reset(1'b0);
    check(dq_oe == 4'b0000, "R1 reset oe", 32'(dq_oe), 32'h0);

    read_txn(8'h03, 32'h0000_0010, 3, "R2 R11 plain read 24-bit");
    read_txn(8'h13, 32'hABCD_0020, 2, "R3 4-byte read flag clear");
    read_txn(8'h0B, 32'h0000_0045, 2, "R7 fast read idle clocks");
    read_txn(8'h3B, 32'h0000_0077, 2, "R8 dual output");
    read_txn(8'hBB, 32'h0000_0081, 2, "R6 dual address lanes");
    read_txn(8'h6B, 32'h0000_0092, 2, "R8 quad output");
    read_txn(8'hEB, 32'h0000_00A3, 2, "R6 quad address lanes");
    read_txn(8'h0C, 32'h1234_0033, 1, "R3 4-byte fast read");
    read_txn(8'h3C, 32'h8000_0044, 1, "R3 4-byte dual output");
    read_txn(8'hBC, 32'hFFFF_FF55, 1, "R3 4-byte dual io");
    read_txn(8'h6C, 32'h0101_0166, 1, "R3 4-byte quad output");
    read_txn(8'hEC, 32'h5A5A_5A77, 1, "R3 4-byte quad io");

    read_txn(8'h03, 32'h0000_00FE, 4, "R9 wrap past top");
    read_txn(8'hEB, 32'h0000_0010, 20, "R9 long burst");

    send_cmd(8'hB7);
    read_txn(8'h03, 32'h7700_00C1, 2, "R4 plain read 32-bit after enter");
    read_txn(8'hEC, 32'h0000_00C5, 1, "R3 4-byte quad io flag set");
    read_txn(8'h0B, 32'h0100_00D0, 1, "R5 flag persists across cs");
    send_cmd(8'hE9);
    read_txn(8'h03, 32'h0000_00D8, 2, "R5 24-bit after exit");

    cs_n = 1'b0;
    for (int i = 0; i < 8; i++) tick({3'b0, 8'h5E >> (7 - i)} & 4'h1, q, oe);
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 40; i++) begin
        tick(4'($urandom), q, oe);
        if (oe != 4'b0000) quiet = 1'b0;
      end
      check(quiet, "R10 unknown command silent", 32'(!quiet), 32'h0);
    end
    idle_check(3, "R1 idle with cs high");
    read_txn(8'h03, 32'h0000_0031, 1, "R10 recovery after reject");

    cs_n = 1'b0;
    for (int i = 0; i < 8; i++) tick({3'b0, 8'h0B >> (7 - i)} & 4'h1, q, oe);
    for (int i = 0; i < 10; i++) tick(4'h1, q, oe);
    idle_check(4, "R1 abort mid address");
    read_txn(8'h0B, 32'h0000_00E0, 2, "R1 fresh command after abort");

    do_reset(1'b1);
    read_txn(8'h03, 32'h0300_0012, 2, "R5 flag from cfg at reset");
    read_txn(8'hBB, 32'h0000_00F0, 1, "R4 dual io 32-bit by cfg");
    send_cmd(8'hE9);
    read_txn(8'h6B, 32'h0000_0023, 1, "R4 quad output 24-bit");

    for (int n = 0; n < 25; n++) begin
      logic [7:0] ops [12] = '{8'h03, 8'h13, 8'h0B, 8'h0C, 8'h3B, 8'h3C,
                                8'hBB, 8'hBC, 8'h6B, 8'h6C, 8'hEB, 8'hEC};
      if ($urandom_range(0, 3) == 0) send_cmd(($urandom_range(0, 1) == 1) ? 8'hB7 : 8'hE9);
      read_txn(ops[$urandom_range(0, 11)], $urandom, $urandom_range(1, 5), "R9 random read");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule